// File: doc/BRIEF.md
# Prescaled Reloadable Countdown Timer

A single-channel countdown timer behind a small register bus. The channel counts down from a value in its current-count register, stepping once per prescaled tick. A 2-bit field picks one of four source strobes, and a 3-bit field divides that source by a power of two. When the count runs out, the channel sets a sticky expiry flag. The interrupt line is that flag gated by a global enable bit.

Each expiry leaves the counter in one of two states. In periodic mode the counter reloads from the interval register and keeps running, which gives a steady tick. In single-shot mode the counter parks at zero and turns its own enable off, which gives one event. Software can also force the interval into the counter by writing the self-clearing reload bit, or can write the counter directly.

The source inputs are per-cycle strobes in the timer's own clock domain. Producing those strobes is outside this block.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Channel control (offset 0x10) bits 3:2 pick which `src_pulse` bit counts as a source pulse. Bits 6:4 hold k, and a tick occurs on every 2^k-th selected pulse while enabled. The prescale phase restarts at zero whenever enable (bit 0) is clear.
- R3: Each tick lowers the count (offset 0x18) by one. A tick that finds the count at 1 or 0 is an expiry, so a count of N expires on the N-th tick.
- R4: Expiry sets status bit 0 (offset 0x04). Writing 1 to that bit clears it, and an expiry in the same cycle wins over the clear.
- R5: With control bit 7 clear (periodic), an expiry loads the interval (offset 0x14) into the count, and counting continues.
- R6: With control bit 7 set (single-shot), an expiry leaves the count at 0 and clears control bit 0.
- R7: Writing control with bit 1 set loads the interval into the count one cycle later. Bit 1 reads 1 for that cycle only. The reload takes precedence over a tick in that cycle, and that tick causes no expiry.
- R8: `irq` equals status bit 0 AND global control bit 0 (offset 0x00).
- R9: While enable is clear, the count holds. A bus write to the count takes precedence over the reload and over a tick.
- R10: Interval and count read back what was written. Any unmapped offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (5) | Byte address of register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| src_pulse | input | 4 | Per-cycle strobes of the four clock sources |
| irq | output | 1 | Interrupt request |

## Verification
A register write lands at the clock edge that samples it, so its read-back and any effect on `irq` appear in the same cycle after that edge. A reload request lands one edge later. An expiry updates the count, the status flag and `irq` at the edge where the final tick is sampled. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge. It compares `rdata` and `irq` shortly after every rising edge, so each result is checked in the exact cycle it is due.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [3:0]    src_pulse,
  output logic          irq
);
  localparam logic [AW-1:0] A_GCTL = AW'(5'h00);
  localparam logic [AW-1:0] A_STS  = AW'(5'h04);
  localparam logic [AW-1:0] A_CTL  = AW'(5'h10);
  localparam logic [AW-1:0] A_IVAL = AW'(5'h14);
  localparam logic [AW-1:0] A_CNT  = AW'(5'h18);

  logic          gie_q, sts_q, en_q, rl_q, os_q;
  logic [1:0]    src_q;
  logic [2:0]    div_q;
  logic [6:0]    pre_q;
  logic [CW-1:0] ival_q, cnt_q;

  wire w_gctl = wr_en && addr == A_GCTL;
  wire w_sts  = wr_en && addr == A_STS;
  wire w_ctl  = wr_en && addr == A_CTL;
  wire w_ival = wr_en && addr == A_IVAL;
  wire w_cnt  = wr_en && addr == A_CNT;

  wire [6:0] pre_max = ~(7'h7f << div_q);
  wire       src_hit = src_pulse[src_q];
  wire       tick    = en_q && src_hit && pre_q == pre_max;
  wire       expire  = tick && !rl_q && cnt_q <= CW'(1);

  assign irq = sts_q & gie_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          pre_q <= '0;
    else if (!en_q)      pre_q <= '0;
    else if (src_hit)    pre_q <= tick ? '0 : pre_q + 7'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cnt_q <= '0;
    else if (w_cnt)      cnt_q <= wdata[CW-1:0];
    else if (rl_q)       cnt_q <= ival_q;
    else if (expire)     cnt_q <= os_q ? '0 : ival_q;
    else if (tick)       cnt_q <= cnt_q - CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= 1'b0; rl_q <= 1'b0; src_q <= '0; div_q <= '0; os_q <= 1'b0;
    end else if (w_ctl) begin
      en_q  <= wdata[0];
      rl_q  <= wdata[1];
      src_q <= wdata[3:2];
      div_q <= wdata[6:4];
      os_q  <= wdata[7];
    end else begin
      rl_q <= 1'b0;
      if (expire && os_q) en_q <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gie_q <= 1'b0; sts_q <= 1'b0; ival_q <= '0;
    end else begin
      if (w_gctl) gie_q <= wdata[0];
      if (w_ival) ival_q <= wdata[CW-1:0];
      if (expire) sts_q <= 1'b1;
      else if (w_sts && wdata[0]) sts_q <= 1'b0;
    end

  always_comb
    case (addr)
      A_GCTL:  rdata = {31'd0, gie_q};
      A_STS:   rdata = {31'd0, sts_q};
      A_CTL:   rdata = {24'd0, os_q, div_q, src_q, rl_q, en_q};
      A_IVAL:  rdata = 32'(ival_q);
      A_CNT:   rdata = 32'(cnt_q);
      default: rdata = '0;
    endcase
endmodule

module tick_timer_chk #(
  parameter int CW = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          irq,
  input logic          gie,
  input logic          sts,
  input logic          en,
  input logic          rl,
  input logic          os,
  input logic [CW-1:0] ival,
  input logic [CW-1:0] cnt,
  input logic          expire
);
  wire cnt_wr = wr_en && addr == AW'(5'h18);
  wire ctl_wr = wr_en && addr == AW'(5'h10);

  p_expire_sets_sts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> sts);
  p_oneshot_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && os && !ctl_wr) |=> !en);
  p_reload_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rl && !cnt_wr) |=> cnt == $past(ival));
  p_reload_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rl && !ctl_wr) |=> !rl);
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie && sts);
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !rl && !cnt_wr) |=> $stable(cnt));
endmodule

bind tick_timer tick_timer_chk #(.CW(CW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .irq(irq),
  .gie(gie_q), .sts(sts_q), .en(en_q), .rl(rl_q), .os(os_q),
  .ival(ival_q), .cnt(cnt_q), .expire(expire)
);

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0]  src_pulse = '0;
  logic        irq;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  tick_timer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_pulse(src_pulse), .irq(irq));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    src_pulse <= {1'b0, (cyc % 3) == 0, (cyc % 2) == 0, 1'b1};
  end

  // behavioural reference
  bit m_gie, m_sts, m_en, m_rl, m_os;
  int m_src, m_div, m_pre;
  logic [31:0] m_ival, m_cnt;

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return {31'd0, m_gie};
      5'h04: return {31'd0, m_sts};
      5'h10: return {24'd0, m_os, 3'(m_div), 2'(m_src), m_rl, m_en};
      5'h14: return m_ival;
      5'h18: return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gie = 0; m_sts = 0; m_en = 0; m_rl = 0; m_os = 0;
      m_src = 0; m_div = 0; m_pre = 0; m_ival = 0; m_cnt = 0;
    end else begin
      bit hit, tk, ex, n_en, n_rl, n_sts;
      int n_pre;
      logic [31:0] n_cnt;
      hit = src_pulse[m_src];
      tk = m_en && hit && (m_pre == (1 << m_div) - 1);
      ex = tk && !m_rl && (m_cnt <= 1);
      n_pre = !m_en ? 0 : (hit ? (tk ? 0 : m_pre + 1) : m_pre);
      n_cnt = m_cnt; n_en = m_en; n_rl = 0; n_sts = m_sts;
      if (m_rl) n_cnt = m_ival;
      else if (ex) n_cnt = m_os ? 0 : m_ival;
      else if (tk) n_cnt = m_cnt - 1;
      if (ex && m_os) n_en = 0;
      if (ex) n_sts = 1;
      else if (wr_en && addr == 5'h04 && wdata[0]) n_sts = 0;
      if (wr_en) case (addr)
        5'h00: m_gie = wdata[0];
        5'h10: begin
          n_en = wdata[0]; n_rl = wdata[1]; m_src = int'(wdata[3:2]);
          m_div = int'(wdata[6:4]); m_os = wdata[7];
        end
        5'h14: m_ival = wdata;
        5'h18: n_cnt = wdata;
        default: ;
      endcase
      m_pre = n_pre; m_cnt = n_cnt; m_en = n_en; m_rl = n_rl; m_sts = n_sts;
    end
    #2;
    if (!done) begin
      check($sformatf("rdata@%h", addr), rdata, m_read(addr));
      check("irq (R8)", {31'd0, irq}, {31'd0, m_sts & m_gie});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic watch(input logic [4:0] a, input int n);
    addr = a;
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1 reset";
    foreach (addr[i]) ;
    watch(5'h00, 1); watch(5'h04, 1); watch(5'h10, 1); watch(5'h14, 1); watch(5'h18, 1);
    rst_n = 1;
    watch(5'h18, 2);
    phase = "R10 map";
    wr(5'h14, 32'hDEAD_0003); watch(5'h14, 1);
    wr(5'h0C, 32'hFFFF_FFFF); watch(5'h0C, 2);
    phase = "R9 hold/write";
    wr(5'h18, 32'd5); watch(5'h18, 6);
    phase = "R7 reload";
    wr(5'h14, 32'd3);
    wr(5'h10, 32'h02); watch(5'h10, 1); watch(5'h18, 3);
    phase = "R2 R3 R5 periodic div4";
    wr(5'h10, 32'h21); watch(5'h18, 30);
    phase = "R8 irq";
    wr(5'h00, 32'h1); watch(5'h04, 10);
    phase = "R4 clear";
    wr(5'h04, 32'h1); watch(5'h04, 12);
    wr(5'h04, 32'h0); watch(5'h04, 4);
    phase = "R2 source 1";
    wr(5'h10, 32'h05); watch(5'h18, 12);
    phase = "R2 source 2 div2";
    wr(5'h10, 32'h19); watch(5'h18, 20);
    phase = "R2 silent source";
    wr(5'h10, 32'h0D); watch(5'h18, 8);
    phase = "R6 single-shot";
    wr(5'h04, 32'h1);
    wr(5'h18, 32'd4);
    wr(5'h10, 32'h81); watch(5'h18, 8); watch(5'h10, 3); watch(5'h04, 2);
    phase = "R6 oneshot zero start";
    wr(5'h10, 32'h81); watch(5'h10, 3);
    phase = "R7 reload with enable";
    wr(5'h14, 32'd2);
    wr(5'h10, 32'h03); watch(5'h18, 10);
    phase = "R9 write over reload";
    @(negedge clk); wr_en = 1; addr = 5'h10; wdata = 32'h02;
    @(negedge clk); addr = 5'h18; wdata = 32'd9;
    @(negedge clk); wr_en = 0; watch(5'h18, 3);
    phase = "R9 disabled";
    wr(5'h10, 32'h00); watch(5'h18, 5);
    report();
  end
endmodule